// File: doc/BRIEF.md
# Register Rename Map with Banked Free List

This block sits in a four-wide decode stage and turns logical register numbers into physical register numbers. Thirty-three logical registers are mapped onto sixty-four physical ones. Every cycle a decode group of up to four instructions presents up to three source operands and one optional destination per slot. The block returns the physical register behind each source, along with a busy bit saying whether that register still waits for its single write. Each destination gets a fresh physical register from the free list, and the mapping it replaces is returned so that the caller can save it until the instruction graduates.

The free list is one circular queue of 32 entries spread over four 8-deep banks. Consecutive queue positions fall in consecutive banks, so four pops and four pushes each cycle touch every bank at most once. Graduation pushes old physical registers back in slot order. A writeback port clears busy bits. When the group needs more registers than the free list holds, the block stalls the whole group and changes no state for it.

Top module: `rename_map_unit`

## Requirements
- R1: After reset logical register i maps to physical register i, every busy bit is clear, and the free list holds physical registers 33 to 63 in ascending order.
- R2: A source operand that no earlier slot of the group writes gets the current mapping of its logical register, with the busy bit of that physical register as held at the start of the cycle.
- R3: A source operand that an earlier valid slot of the same group writes gets the new physical register of the nearest such earlier slot, and reports busy 1.
- R4: `old_phys_o` of an allocating slot is the mapping its destination had just before that slot, which includes writes by earlier slots of the same group.
- R5: Slots with both `dec_valid_i` and `dec_dst_valid_i` set take free-list entries from the head, in slot order. Other slots take none and show 0 on `dst_phys_o`.
- R6: `stall_o` is high exactly when the group's destination count exceeds the number of free registers. A stalled group changes neither the map, nor the busy bits it would set, nor the free-list head.
- R7: A register handed out on an accepted cycle reads busy from the next cycle on, until it is written back.
- R8: `wb_valid_i` with `wb_phys_i` clears that register's busy bit from the next cycle.
- R9: Registers presented on `grad_valid_i`/`grad_phys_i` are appended to the free-list tail in slot order, up to four per cycle, and can be allocated from the next cycle.
- R10: When several slots of an accepted group write the same logical register, the map keeps the highest slot's new register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 4 | Slot holds an instruction |
| dec_src_i | input | 4x3x6 | Logical source numbers per slot |
| dec_dst_valid_i | input | 4 | Slot writes a destination |
| dec_dst_i | input | 4x6 | Logical destination per slot |
| src_phys_o | output | 4x3x6 | Physical source registers |
| src_busy_o | output | 4x3 | Source not yet written |
| dst_phys_o | output | 4x6 | Newly allocated destination register |
| old_phys_o | output | 4x6 | Replaced destination mapping |
| stall_o | output | 1 | Group cannot be renamed this cycle |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_phys_i | input | 6 | Physical register written back |
| grad_valid_i | input | 4 | Graduation release per slot |
| grad_phys_i | input | 4x6 | Physical register released per slot |

## Verification
First, a sweep reads all 33 logical registers with no destinations, which separates a correct reset mapping from any shifted or stale map. Groups that reuse one destination, and whose later sources read earlier destinations, show whether forwarding picks the nearest writer and whether the old mapping is chained inside the group. Draining the free list to fewer entries than the destination count shows the stall boundary. A release made while the list is drained, and allocated on the next cycle, shows FIFO order through the banks. A long stream of random groups, writebacks and graduations, checked against an arithmetic model, covers bank wrap-around and mixed valid patterns.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int NUM_LOG       = 33;
  localparam int NUM_PHYS      = 64;
  localparam int GROUP         = 4;
  localparam int NUM_SRC       = 3;
  localparam int FL_BANKS      = GROUP;
  localparam int FL_BANK_DEPTH = 8;

  localparam int LOG_W       = $clog2(NUM_LOG);
  localparam int PHYS_W      = $clog2(NUM_PHYS);
  localparam int FL_SIZE     = FL_BANKS * FL_BANK_DEPTH;
  localparam int FL_PTR_W    = $clog2(FL_SIZE);
  localparam int FL_CNT_W    = $clog2(FL_SIZE + 1);
  localparam int BANK_SEL_W  = $clog2(FL_BANKS);
  localparam int BANK_ADDR_W = $clog2(FL_BANK_DEPTH);
  localparam int GRP_CNT_W   = $clog2(GROUP + 1);
  localparam int GRP_IDX_W   = $clog2(GROUP);
  localparam int INIT_FREE   = NUM_PHYS - NUM_LOG;
endpackage

// File: rtl/rename_free_bank.sv
module rename_free_bank
  import rename_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [BANK_ADDR_W-1:0] waddr_i,
  input  logic [PHYS_W-1:0]      wdata_i,
  input  logic [BANK_ADDR_W-1:0] raddr_i,
  output logic [PHYS_W-1:0]      rdata_o
);
  logic [FL_BANK_DEPTH-1:0][PHYS_W-1:0] mem_q;

  // queue position s*FL_BANKS+BANK_ID holds free reg NUM_LOG+position at reset
  function automatic logic [PHYS_W-1:0] init_val(int s);
    int pos;
    pos = s * FL_BANKS + BANK_ID;
    return (pos < INIT_FREE) ? PHYS_W'(NUM_LOG + pos) : '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < FL_BANK_DEPTH; s++) mem_q[s] <= init_val(s);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
  import rename_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [GRP_CNT_W-1:0]         pop_cnt_i,
  input  logic [GROUP-1:0]             push_valid_i,
  input  logic [GROUP-1:0][PHYS_W-1:0] push_phys_i,
  output logic [GROUP-1:0][PHYS_W-1:0] pop_phys_o,
  output logic [FL_CNT_W-1:0]          count_o
);
  localparam int SUM_W = FL_CNT_W + 1;

  logic [FL_PTR_W-1:0]          head_q, tail_q;
  logic [FL_CNT_W-1:0]          count_q;
  logic [GRP_CNT_W-1:0]         push_cnt;
  logic [GROUP-1:0][PHYS_W-1:0] push_pack;
  logic [FL_BANKS-1:0][PHYS_W-1:0] bank_rdata;

  // compact valid releases to consecutive tail positions
  always_comb begin
    push_cnt  = '0;
    push_pack = '0;
    for (int j = 0; j < GROUP; j++) begin
      if (push_valid_i[j]) begin
        push_pack[push_cnt[GRP_IDX_W-1:0]] = push_phys_i[j];
        push_cnt = push_cnt + GRP_CNT_W'(1);
      end
    end
  end

  for (genvar b = 0; b < FL_BANKS; b++) begin : g_bank
    logic [BANK_SEL_W-1:0] rd_off, wr_off;
    logic [FL_PTR_W-1:0]   rd_pos, wr_pos;
    logic                  bank_we;

    assign rd_off  = BANK_SEL_W'(b) - head_q[BANK_SEL_W-1:0];
    assign rd_pos  = head_q + FL_PTR_W'(rd_off);
    assign wr_off  = BANK_SEL_W'(b) - tail_q[BANK_SEL_W-1:0];
    assign wr_pos  = tail_q + FL_PTR_W'(wr_off);
    assign bank_we = GRP_CNT_W'(wr_off) < push_cnt;

    rename_free_bank #(.BANK_ID(b)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .waddr_i (wr_pos[FL_PTR_W-1:BANK_SEL_W]),
      .wdata_i (push_pack[wr_off]),
      .raddr_i (rd_pos[FL_PTR_W-1:BANK_SEL_W]),
      .rdata_o (bank_rdata[b])
    );
  end

  always_comb begin
    for (int j = 0; j < GROUP; j++) begin
      pop_phys_o[j] = bank_rdata[head_q[BANK_SEL_W-1:0] + BANK_SEL_W'(j)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= FL_PTR_W'(INIT_FREE);
      count_q <= FL_CNT_W'(INIT_FREE);
    end else begin
      head_q  <= head_q + FL_PTR_W'(pop_cnt_i);
      tail_q  <= tail_q + FL_PTR_W'(push_cnt);
      count_q <= count_q + FL_CNT_W'(push_cnt) - FL_CNT_W'(pop_cnt_i);
    end
  end

  assign count_o = count_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SUM_W'(count_q) + SUM_W'(push_cnt)) <= SUM_W'(FL_SIZE));

  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    FL_CNT_W'(pop_cnt_i) <= count_q);

  // R9
  count_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_cnt_i == '0 && push_cnt == '0) |=> $stable(count_q));
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rename_pkg::*;
(
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [GROUP-1:0]                         dec_valid_i,
  input  logic [GROUP-1:0][NUM_SRC-1:0][LOG_W-1:0] dec_src_i,
  input  logic [GROUP-1:0]                         dec_dst_valid_i,
  input  logic [GROUP-1:0][LOG_W-1:0]              dec_dst_i,
  input  logic [GROUP-1:0][PHYS_W-1:0]             new_phys_i,
  input  logic                                     commit_i,
  output logic [GROUP-1:0][NUM_SRC-1:0][PHYS_W-1:0] src_phys_o,
  output logic [GROUP-1:0][NUM_SRC-1:0]            src_fwd_o,
  output logic [GROUP-1:0][PHYS_W-1:0]             old_phys_o
);
  logic [NUM_LOG-1:0][PHYS_W-1:0] map_q;
  logic [GROUP-1:0]               writes;

  assign writes = dec_valid_i & dec_dst_valid_i;

  function automatic logic [PHYS_W-1:0] lookup(logic [LOG_W-1:0] r);
    return (r < LOG_W'(NUM_LOG)) ? map_q[r] : '0;
  endfunction

  // later slots see the nearest earlier writer in the group
  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      old_phys_o[i] = lookup(dec_dst_i[i]);
      for (int j = 0; j < i; j++) begin
        if (writes[j] && dec_dst_i[j] == dec_dst_i[i]) old_phys_o[i] = new_phys_i[j];
      end
      for (int s = 0; s < NUM_SRC; s++) begin
        src_phys_o[i][s] = lookup(dec_src_i[i][s]);
        src_fwd_o[i][s]  = 1'b0;
        for (int j = 0; j < i; j++) begin
          if (writes[j] && dec_dst_i[j] == dec_src_i[i][s]) begin
            src_phys_o[i][s] = new_phys_i[j];
            src_fwd_o[i][s]  = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_LOG; k++) map_q[k] <= PHYS_W'(k);
    end else if (commit_i) begin
      for (int i = 0; i < GROUP; i++) begin
        if (writes[i] && dec_dst_i[i] < LOG_W'(NUM_LOG)) map_q[dec_dst_i[i]] <= new_phys_i[i];
      end
    end
  end

  // R10
  last_writer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && writes[GROUP-1] && dec_dst_i[GROUP-1] < LOG_W'(NUM_LOG))
    |=> map_q[$past(dec_dst_i[GROUP-1])] == $past(new_phys_i[GROUP-1]));

  // R6
  map_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(map_q));
endmodule

// File: rtl/rename_busy_table.sv
module rename_busy_table
  import rename_pkg::*;
(
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [GROUP-1:0]                          set_valid_i,
  input  logic [GROUP-1:0][PHYS_W-1:0]              set_phys_i,
  input  logic                                      clr_valid_i,
  input  logic [PHYS_W-1:0]                         clr_phys_i,
  input  logic [GROUP-1:0][NUM_SRC-1:0][PHYS_W-1:0] rd_phys_i,
  output logic [GROUP-1:0][NUM_SRC-1:0]             rd_busy_o
);
  logic [NUM_PHYS-1:0] busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else begin
      if (clr_valid_i) busy_q[clr_phys_i] <= 1'b0;
      for (int i = 0; i < GROUP; i++) begin
        if (set_valid_i[i]) busy_q[set_phys_i[i]] <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      for (int s = 0; s < NUM_SRC; s++) rd_busy_o[i][s] = busy_q[rd_phys_i[i][s]];
    end
  end

  // R7
  alloc_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_i[0] |=> busy_q[$past(set_phys_i[0])]);

  // R8
  wb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_valid_i && set_valid_i == '0) |=> !busy_q[$past(clr_phys_i)]);
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit
  import rename_pkg::*;
(
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [GROUP-1:0]                          dec_valid_i,
  input  logic [GROUP-1:0][NUM_SRC-1:0][LOG_W-1:0]  dec_src_i,
  input  logic [GROUP-1:0]                          dec_dst_valid_i,
  input  logic [GROUP-1:0][LOG_W-1:0]               dec_dst_i,
  output logic [GROUP-1:0][NUM_SRC-1:0][PHYS_W-1:0] src_phys_o,
  output logic [GROUP-1:0][NUM_SRC-1:0]             src_busy_o,
  output logic [GROUP-1:0][PHYS_W-1:0]              dst_phys_o,
  output logic [GROUP-1:0][PHYS_W-1:0]              old_phys_o,
  output logic                                      stall_o,
  input  logic                                      wb_valid_i,
  input  logic [PHYS_W-1:0]                         wb_phys_i,
  input  logic [GROUP-1:0]                          grad_valid_i,
  input  logic [GROUP-1:0][PHYS_W-1:0]              grad_phys_i
);
  logic [GROUP-1:0]                          alloc;
  logic [GROUP-1:0][GRP_CNT_W-1:0]           alloc_idx;
  logic [GRP_CNT_W-1:0]                      need;
  logic [GRP_CNT_W-1:0]                      pop_cnt;
  logic                                      commit;
  logic [FL_CNT_W-1:0]                       fl_count;
  logic [GROUP-1:0][PHYS_W-1:0]              pop_phys;
  logic [GROUP-1:0][PHYS_W-1:0]              new_phys;
  logic [GROUP-1:0][NUM_SRC-1:0]             src_fwd;
  logic [GROUP-1:0][NUM_SRC-1:0]             busy_rd;

  assign alloc = dec_valid_i & dec_dst_valid_i;

  always_comb begin
    need = '0;
    for (int i = 0; i < GROUP; i++) begin
      alloc_idx[i] = need;
      if (alloc[i]) need = need + GRP_CNT_W'(1);
    end
  end

  assign stall_o = FL_CNT_W'(need) > fl_count;
  assign commit  = !stall_o;
  assign pop_cnt = commit ? need : '0;

  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      new_phys[i]   = pop_phys[alloc_idx[i][GRP_IDX_W-1:0]];
      dst_phys_o[i] = (alloc[i] && commit) ? new_phys[i] : '0;
    end
  end

  rename_free_list u_free (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pop_cnt_i    (pop_cnt),
    .push_valid_i (grad_valid_i),
    .push_phys_i  (grad_phys_i),
    .pop_phys_o   (pop_phys),
    .count_o      (fl_count)
  );

  rename_map_table u_map (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .dec_valid_i     (dec_valid_i),
    .dec_src_i       (dec_src_i),
    .dec_dst_valid_i (dec_dst_valid_i),
    .dec_dst_i       (dec_dst_i),
    .new_phys_i      (new_phys),
    .commit_i        (commit),
    .src_phys_o      (src_phys_o),
    .src_fwd_o       (src_fwd),
    .old_phys_o      (old_phys_o)
  );

  rename_busy_table u_busy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_valid_i (alloc & {GROUP{commit}}),
    .set_phys_i  (new_phys),
    .clr_valid_i (wb_valid_i),
    .clr_phys_i  (wb_phys_i),
    .rd_phys_i   (src_phys_o),
    .rd_busy_o   (busy_rd)
  );

  assign src_busy_o = src_fwd | busy_rd;

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && grad_valid_i == '0) |=> $stable(fl_count));

  // R5
  alloc_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && alloc[0] && alloc[1]) |-> dst_phys_o[0] != dst_phys_o[1]);

  // R3
  fwd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i[1] && alloc[0] && dec_src_i[1][0] == dec_dst_i[0])
    |-> (src_busy_o[1][0] && src_phys_o[1][0] == new_phys[0]));
endmodule

// File: tb/rename_map_unit_test.sv
module rename_map_unit_test;
  import rename_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [GROUP-1:0]                          dv, ddv, gv, sw_unused;
  logic [GROUP-1:0][NUM_SRC-1:0][LOG_W-1:0]  ds;
  logic [GROUP-1:0][LOG_W-1:0]               dd;
  logic [GROUP-1:0][NUM_SRC-1:0][PHYS_W-1:0] sp;
  logic [GROUP-1:0][NUM_SRC-1:0]             sb;
  logic [GROUP-1:0][PHYS_W-1:0]              dp, op, gp;
  logic                                      stall, wb_v;
  logic [PHYS_W-1:0]                         wb_p;

  int total = 0, bad = 0;
  int map_m[NUM_LOG];
  bit busy_m[NUM_PHYS];
  int fl_q[$];
  int ret_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_map_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_valid_i(dv), .dec_src_i(ds), .dec_dst_valid_i(ddv), .dec_dst_i(dd),
    .src_phys_o(sp), .src_busy_o(sb), .dst_phys_o(dp), .old_phys_o(op),
    .stall_o(stall), .wb_valid_i(wb_v), .wb_phys_i(wb_p),
    .grad_valid_i(gv), .grad_phys_i(gp)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    dv = '0; ddv = '0; ds = '0; dd = '0; wb_v = 1'b0; wb_p = '0; gv = '0; gp = '0;
    sw_unused = '0;
  endtask

  // compare the current group against the model, then advance one cycle
  task automatic step();
    int need, k, lg, ep;
    bit exp_stall;
    int tmap[NUM_LOG];
    bit tbusy[NUM_PHYS];
    bit grp[NUM_LOG];
    int newp[GROUP];
    int olds[GROUP];
    #1;
    need = 0;
    for (int i = 0; i < GROUP; i++) if (dv[i] && ddv[i]) need++;
    exp_stall = need > fl_q.size();
    chk(stall == exp_stall, "R6", int'(stall), int'(exp_stall));
    tmap = map_m; tbusy = busy_m; k = 0;
    for (int n = 0; n < NUM_LOG; n++) grp[n] = 1'b0;
    if (!exp_stall) begin
      for (int i = 0; i < GROUP; i++) begin
        if (dv[i]) begin
          for (int s = 0; s < NUM_SRC; s++) begin
            lg = int'(ds[i][s]); ep = tmap[lg];
            chk(int'(sp[i][s]) == ep, grp[lg] ? "R3" : "R2", int'(sp[i][s]), ep);
            chk(sb[i][s] == tbusy[ep], grp[lg] ? "R3" : "R7", int'(sb[i][s]), int'(tbusy[ep]));
          end
          if (ddv[i]) begin
            newp[k] = fl_q[k];
            chk(int'(dp[i]) == newp[k], "R5", int'(dp[i]), newp[k]);
            olds[k] = tmap[int'(dd[i])];
            chk(int'(op[i]) == olds[k], "R4", int'(op[i]), olds[k]);
            tmap[int'(dd[i])] = newp[k];
            tbusy[newp[k]] = 1'b1;
            grp[int'(dd[i])] = 1'b1;
            k++;
          end else begin
            chk(dp[i] == '0, "R5", int'(dp[i]), 0);
          end
        end
      end
    end
    @(posedge clk);
    if (!exp_stall) begin
      map_m = tmap;
      for (int n = 0; n < k; n++) begin
        void'(fl_q.pop_front());
        ret_q.push_back(olds[n]);
      end
    end
    if (wb_v) busy_m[int'(wb_p)] = 1'b0;
    if (!exp_stall) for (int n = 0; n < k; n++) busy_m[newp[n]] = 1'b1;
    for (int i = 0; i < GROUP; i++) if (gv[i]) fl_q.push_back(int'(gp[i]));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fx, p;
    clear_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NUM_LOG; i++) map_m[i] = i;
    for (int i = 0; i < NUM_PHYS; i++) busy_m[i] = 1'b0;
    for (int i = NUM_LOG; i < NUM_PHYS; i++) fl_q.push_back(i);

    // R1: identity map sweep, no destinations
    for (int base = 0; base < NUM_LOG; base += GROUP * NUM_SRC) begin
      dv = '1; ddv = '0;
      for (int i = 0; i < GROUP; i++)
        for (int s = 0; s < NUM_SRC; s++) ds[i][s] = LOG_W'((base + i * NUM_SRC + s) % NUM_LOG);
      #1;
      chk(!stall, "R1", int'(stall), 0);
      for (int i = 0; i < GROUP; i++)
        for (int s = 0; s < NUM_SRC; s++) begin
          chk(sp[i][s] == PHYS_W'(ds[i][s]), "R1", int'(sp[i][s]), int'(ds[i][s]));
          chk(!sb[i][s], "R1", int'(sb[i][s]), 0);
        end
      step();
    end

    // R5 R3 R4: chained destinations in one group
    clear_in();
    dv = '1; ddv = '1;
    dd[0] = 6'd1; dd[1] = 6'd2; dd[2] = 6'd3; dd[3] = 6'd1;
    ds[1][0] = 6'd1; ds[2][0] = 6'd2; ds[3][0] = 6'd1;
    #1;
    for (int i = 0; i < GROUP; i++) chk(int'(dp[i]) == NUM_LOG + i, "R5", int'(dp[i]), NUM_LOG + i);
    chk(int'(sp[1][0]) == NUM_LOG, "R3", int'(sp[1][0]), NUM_LOG);
    chk(sb[1][0] == 1'b1, "R3", int'(sb[1][0]), 1);
    chk(int'(op[0]) == 1, "R4", int'(op[0]), 1);
    chk(int'(op[3]) == NUM_LOG, "R4", int'(op[3]), NUM_LOG);
    step();

    // R10 R7 then R8
    clear_in();
    dv[0] = 1'b1; ds[0][0] = 6'd1;
    #1;
    p = int'(sp[0][0]);
    chk(p == NUM_LOG + 3, "R10", p, NUM_LOG + 3);
    chk(sb[0][0] == 1'b1, "R7", int'(sb[0][0]), 1);
    wb_v = 1'b1; wb_p = PHYS_W'(p);
    step();
    wb_v = 1'b0;
    #1;
    chk(sb[0][0] == 1'b0, "R8", int'(sb[0][0]), 0);
    step();

    // drain free list
    clear_in();
    dv = '1; ddv = '1;
    for (int i = 0; i < GROUP; i++) dd[i] = LOG_W'(10 + i);
    while (fl_q.size() >= GROUP) step();
    #1;
    chk(stall == 1'b1, "R6", int'(stall), 1);
    fx = ret_q.pop_front();
    gv[0] = 1'b1; gp[0] = PHYS_W'(fx);
    step();
    gv = '0;
    #1;
    chk(stall == 1'b0, "R6", int'(stall), 0);
    chk(int'(dp[GROUP-1]) == fx, "R9", int'(dp[GROUP-1]), fx);
    step();
    ddv = '0;
    #1;
    chk(stall == 1'b0, "R6", int'(stall), 0);
    step();

    // random traffic
    for (int c = 0; c < 1500; c++) begin
      int ng;
      clear_in();
      dv = GROUP'($urandom);
      ddv = GROUP'($urandom);
      for (int i = 0; i < GROUP; i++) begin
        dd[i] = LOG_W'($urandom_range(0, NUM_LOG - 1));
        for (int s = 0; s < NUM_SRC; s++) ds[i][s] = LOG_W'($urandom_range(0, NUM_LOG - 1));
      end
      wb_v = 1'($urandom);
      wb_p = PHYS_W'($urandom_range(0, NUM_PHYS - 1));
      ng = $urandom_range(0, GROUP);
      for (int i = 0; i < GROUP; i++) begin
        if (i < ng && ret_q.size() > 0) begin
          gv[i] = 1'b1; gp[i] = PHYS_W'(ret_q.pop_front());
        end
      end
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule